// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control and status registers that sits on a simple two-phase peripheral bus (select, enable, write, address, write data, byte strobes and read data) and decodes a 4 KB window. Software uses it to read the cause of the last reset, to mask reset sources, to hold a word across warm resets, to program the initial secure vector table address, to hold processors in wait and to configure the wakeup interrupt controller. A secure debug status word is changed only through separate set and clear aliases, and a write-only register lets software request a system reset. The request leaves the block as a one-cycle pulse.

Two reset inputs are used. The power-on reset clears every register. The warm reset clears every register except the general retention word. A read-only table of twelve identification words sits at the top of the window. Every access finishes in one access cycle, and the block never answers with an error.

Top module: `sysctl_regbank`

## Requirements
- R1: On reset the reset syndrome (offset 0x100) reads 0x00000001 and the initial secure vector (0x110) reads 0x10000000. The debug status (0x000), reset mask (0x104), CPU wait (0x118) and wakeup control (0x120) read zero.
- R2: The retention word (0x10C) keeps its value through a warm reset (rst_n low while por_n is high). Only por_n low clears it.
- R3: A write to the set alias (0x004) ORs the written value into the debug status word. A write to the clear alias (0x008) clears the status bits that are 1 in the written value.
- R4: The registers at 0x100, 0x104, 0x10C, 0x110, 0x118 and 0x120 read back the last value written to them.
- R5: Reads of the write-only offsets 0x004, 0x008 and 0x108 return zero.
- R6: Writes to the debug status word (0x000), the bus wait word (0x11C) and the ID words are ignored. The bus wait word always reads zero.
- R7: The ID words at 0xFD0 to 0xFFC, in steps of 4, read in address order 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: Byte strobe bit i qualifies write data bits 8i+7..8i. A byte whose strobe is low is written as zero; it does not keep its old value.
- R9: An accepted write to 0x108 with bit 9 of the strobed data set gives sys_reset_req high for exactly the cycle after the access. Writes there with bit 9 clear have no effect. sys_reset_req is low during reset.
- R10: Offsets with no register read zero, and writes to them change no register.
- R11: bus_ready is always high. bus_rdata is valid in the access cycle of a read (select and enable high, write low) and is zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears every register |
| rst_n | input | 1 | Warm reset, active low, asynchronous; spares the retention word |
| bus_sel | input | 1 | Peripheral select |
| bus_enable | input | 1 | Access phase marker |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Write byte strobes |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access complete, always high |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench checks that a warm reset leaves the retention word alone while a power-on reset clears it. A design with the retention flop on the wrong reset would lose the value or keep a stale one. It sets and clears overlapping status bits through the two aliases. A design that treated either alias as a plain store would wipe bits that should stay. It writes single lanes and a half-word to read/write registers to show that unstrobed bytes become zero, not their old contents. It writes the reset register with every bit except bit 9 set and finds no pulse, writes it with only bit 9 and finds exactly one pulse, and probes unmapped offsets and read-only words with data that would be visible if any of those writes leaked into a register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    // Byte offsets of the register map
    localparam int unsigned OFF_DBG_STAT  = 32'h000;
    localparam int unsigned OFF_DBG_SET   = 32'h004;
    localparam int unsigned OFF_DBG_CLR   = 32'h008;
    localparam int unsigned OFF_SYNDROME  = 32'h100;
    localparam int unsigned OFF_RST_MASK  = 32'h104;
    localparam int unsigned OFF_SW_RESET  = 32'h108;
    localparam int unsigned OFF_RETAIN    = 32'h10C;
    localparam int unsigned OFF_SVEC      = 32'h110;
    localparam int unsigned OFF_CPU_HOLD  = 32'h118;
    localparam int unsigned OFF_BUS_HOLD  = 32'h11C;
    localparam int unsigned OFF_WAKE_CTL  = 32'h120;
    localparam int unsigned OFF_ID_FIRST  = 32'hFD0;
    localparam int unsigned ID_WORDS      = 12;

    // Reset values
    localparam logic [DATA_W-1:0] RV_SYNDROME = 32'h0000_0001;
    localparam logic [DATA_W-1:0] RV_SVEC     = 32'h1000_0000;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DBG_STAT,
        SEL_DBG_SET,
        SEL_DBG_CLR,
        SEL_SYNDROME,
        SEL_RST_MASK,
        SEL_SW_RESET,
        SEL_RETAIN,
        SEL_SVEC,
        SEL_CPU_HOLD,
        SEL_BUS_HOLD,
        SEL_WAKE_CTL,
        SEL_ID
    } reg_sel_e;

    // State cleared by the warm reset
    typedef struct packed {
        logic [DATA_W-1:0] dbg_stat;
        logic [DATA_W-1:0] syndrome;
        logic [DATA_W-1:0] rst_mask;
        logic [DATA_W-1:0] svec;
        logic [DATA_W-1:0] cpu_hold;
        logic [DATA_W-1:0] wake_ctl;
        logic              rst_req;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{
        dbg_stat: '0,
        syndrome: RV_SYNDROME,
        rst_mask: '0,
        svec:     RV_SVEC,
        cpu_hold: '0,
        wake_ctl: '0,
        rst_req:  1'b0
    };

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int ID_COUNT = ID_WORDS,
    parameter int IDX_W    = $clog2(ID_COUNT)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  id_idx
);
    localparam int WORD_W = ADDR_W - 2;

    localparam logic [WORD_W-1:0] W_DBG_STAT = WORD_W'(OFF_DBG_STAT >> 2);
    localparam logic [WORD_W-1:0] W_DBG_SET  = WORD_W'(OFF_DBG_SET  >> 2);
    localparam logic [WORD_W-1:0] W_DBG_CLR  = WORD_W'(OFF_DBG_CLR  >> 2);
    localparam logic [WORD_W-1:0] W_SYNDROME = WORD_W'(OFF_SYNDROME >> 2);
    localparam logic [WORD_W-1:0] W_RST_MASK = WORD_W'(OFF_RST_MASK >> 2);
    localparam logic [WORD_W-1:0] W_SW_RESET = WORD_W'(OFF_SW_RESET >> 2);
    localparam logic [WORD_W-1:0] W_RETAIN   = WORD_W'(OFF_RETAIN   >> 2);
    localparam logic [WORD_W-1:0] W_SVEC     = WORD_W'(OFF_SVEC     >> 2);
    localparam logic [WORD_W-1:0] W_CPU_HOLD = WORD_W'(OFF_CPU_HOLD >> 2);
    localparam logic [WORD_W-1:0] W_BUS_HOLD = WORD_W'(OFF_BUS_HOLD >> 2);
    localparam logic [WORD_W-1:0] W_WAKE_CTL = WORD_W'(OFF_WAKE_CTL >> 2);
    localparam logic [WORD_W-1:0] W_ID_LO    = WORD_W'(OFF_ID_FIRST >> 2);
    localparam logic [WORD_W:0]   W_ID_END   = (WORD_W+1)'(OFF_ID_FIRST >> 2)
                                             + (WORD_W+1)'(ID_COUNT);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] id_off;
    logic              in_id;

    assign word   = addr[ADDR_W-1:2];
    assign id_off = word - W_ID_LO;
    assign in_id  = (word >= W_ID_LO) && ({1'b0, word} < W_ID_END);

    always_comb begin
        sel = SEL_NONE;
        if (in_id) begin
            sel = SEL_ID;
        end else begin
            case (word)
                W_DBG_STAT: sel = SEL_DBG_STAT;
                W_DBG_SET:  sel = SEL_DBG_SET;
                W_DBG_CLR:  sel = SEL_DBG_CLR;
                W_SYNDROME: sel = SEL_SYNDROME;
                W_RST_MASK: sel = SEL_RST_MASK;
                W_SW_RESET: sel = SEL_SW_RESET;
                W_RETAIN:   sel = SEL_RETAIN;
                W_SVEC:     sel = SEL_SVEC;
                W_CPU_HOLD: sel = SEL_CPU_HOLD;
                W_BUS_HOLD: sel = SEL_BUS_HOLD;
                W_WAKE_CTL: sel = SEL_WAKE_CTL;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    assign id_idx = in_id ? id_off[IDX_W-1:0] : '0;

endmodule

// File: rtl/sysctl_id_rom.sv
module sysctl_id_rom
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    // Identification words, listed by ascending address
    always_comb begin
        case (idx)
            IDX_W'(0):  word = 32'h04;
            IDX_W'(1):  word = 32'h00;
            IDX_W'(2):  word = 32'h00;
            IDX_W'(3):  word = 32'h00;
            IDX_W'(4):  word = 32'h54;
            IDX_W'(5):  word = 32'hB8;
            IDX_W'(6):  word = 32'h0B;
            IDX_W'(7):  word = 32'h00;
            IDX_W'(8):  word = 32'h0D;
            IDX_W'(9):  word = 32'hF0;
            IDX_W'(10): word = 32'h05;
            IDX_W'(11): word = 32'hB1;
            default:    word = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_lane_mask.sv
module sysctl_lane_mask
    import sysctl_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    output logic [DATA_W-1:0] wval
);
    // Unstrobed lanes are forced to zero, giving a zero-padded word
    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
        assign wval[8*g +: 8] = strb[g] ? wdata[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int RSTREQ_BIT  = 9,
    parameter int ID_COUNT    = ID_WORDS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_strb,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              sys_reset_req
);
    localparam int IDX_W = $clog2(ID_COUNT);

    logic              sys_rst_n;
    logic              wr_fire;
    logic              rd_fire;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  id_idx;
    logic [DATA_W-1:0] id_word;
    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] rd_word;

    ctl_state_t        st_d, st_q;
    logic [DATA_W-1:0] retain_d, retain_q;

    assign sys_rst_n = por_n & rst_n;
    assign wr_fire   = bus_sel & bus_enable & bus_write;
    assign rd_fire   = bus_sel & bus_enable & ~bus_write;

    sysctl_addr_dec #(
        .ADDR_W   (ADDR_W),
        .ID_COUNT (ID_COUNT),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    sysctl_id_rom #(
        .IDX_W (IDX_W)
    ) u_idrom (
        .idx  (id_idx),
        .word (id_word)
    );

    sysctl_lane_mask u_mask (
        .wdata (bus_wdata),
        .strb  (bus_strb),
        .wval  (wval)
    );

    // Next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        retain_d     = retain_q;
        if (wr_fire) begin
            case (sel)
                SEL_DBG_SET:  st_d.dbg_stat = st_q.dbg_stat | wval;
                SEL_DBG_CLR:  st_d.dbg_stat = st_q.dbg_stat & ~wval;
                SEL_SYNDROME: st_d.syndrome = wval;
                SEL_RST_MASK: st_d.rst_mask = wval;
                SEL_SW_RESET: st_d.rst_req  = wval[RSTREQ_BIT];
                SEL_RETAIN:   retain_d      = wval;
                SEL_SVEC:     st_d.svec     = wval;
                SEL_CPU_HOLD: st_d.cpu_hold = wval;
                SEL_WAKE_CTL: st_d.wake_ctl = wval;
                default:      ;
            endcase
        end
    end

    // Warm-domain state
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // Retention word: power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            retain_q <= '0;
        end else begin
            retain_q <= retain_d;
        end
    end

    // Read multiplexer
    always_comb begin
        case (sel)
            SEL_DBG_STAT: rd_word = st_q.dbg_stat;
            SEL_SYNDROME: rd_word = st_q.syndrome;
            SEL_RST_MASK: rd_word = st_q.rst_mask;
            SEL_RETAIN:   rd_word = retain_q;
            SEL_SVEC:     rd_word = st_q.svec;
            SEL_CPU_HOLD: rd_word = st_q.cpu_hold;
            SEL_WAKE_CTL: rd_word = st_q.wake_ctl;
            SEL_ID:       rd_word = id_word;
            default:      rd_word = '0;
        endcase
    end

    assign bus_rdata     = rd_fire ? rd_word : '0;
    assign bus_ready     = 1'b1;
    assign sys_reset_req = st_q.rst_req;

    // R3
    dbg_set_or_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (wr_fire && sel == SEL_DBG_SET) |=> ((st_q.dbg_stat & $past(wval)) == $past(wval)));

    // R3
    dbg_clr_andnot_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (wr_fire && sel == SEL_DBG_CLR) |=> ((st_q.dbg_stat & $past(wval)) == '0));

    // R6
    dbg_stat_ro_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !(wr_fire && (sel == SEL_DBG_SET || sel == SEL_DBG_CLR)) |=> $stable(st_q.dbg_stat));

    // R2
    retain_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_sel && bus_enable && bus_write && sel == SEL_RETAIN) |=> $stable(retain_q));

    // R9
    rstreq_cause_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(sys_reset_req) |-> $past(bus_sel && bus_enable && bus_write &&
                                       sel == SEL_SW_RESET && bus_wdata[RSTREQ_BIT]));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !(bus_sel && bus_enable && !bus_write) |-> (bus_rdata == '0));

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b1;
    logic        rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_enable = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        sys_reset_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Behavioural reference model
    logic [31:0] m_stat, m_synd, m_mask, m_ret, m_vec, m_cpu, m_wake;
    logic        exp_req = 1'b0;

    always #4 clk = ~clk;

    sysctl_regbank u_dut (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_enable    (bus_enable),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_strb      (bus_strb),
        .bus_rdata     (bus_rdata),
        .bus_ready     (bus_ready),
        .sys_reset_req (sys_reset_req)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [31:0] d, input logic [3:0] s);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (s[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] id_value(input int k);
        logic [31:0] r;
        case (k)
            0: r = 32'h04;  1: r = 32'h00;  2: r = 32'h00;  3: r = 32'h00;
            4: r = 32'h54;  5: r = 32'hB8;  6: r = 32'h0B;  7: r = 32'h00;
            8: r = 32'h0D;  9: r = 32'hF0; 10: r = 32'h05; 11: r = 32'hB1;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int w = int'(a[11:2]) * 4;
        if (w >= 'hFD0) return id_value((w - 'hFD0) / 4);
        case (w)
            'h000: return m_stat;
            'h100: return m_synd;
            'h104: return m_mask;
            'h10C: return m_ret;
            'h110: return m_vec;
            'h118: return m_cpu;
            'h120: return m_wake;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] v);
        int w = int'(a[11:2]) * 4;
        case (w)
            'h004: m_stat = m_stat | v;
            'h008: m_stat = m_stat & ~v;
            'h100: m_synd = v;
            'h104: m_mask = v;
            'h108: exp_req = v[9];
            'h10C: m_ret  = v;
            'h110: m_vec  = v;
            'h118: m_cpu  = v;
            'h120: m_wake = v;
            default: ;
        endcase
    endtask

    task automatic model_warm();
        m_stat = 32'h0; m_synd = 32'h1; m_mask = 32'h0;
        m_vec = 32'h1000_0000; m_cpu = 32'h0; m_wake = 32'h0;
        exp_req = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b1;
        bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_enable = 1'b1;
        @(posedge clk);
        model_write(a, lanes(d, s));
        @(negedge clk);
        bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0; bus_strb = '0;
        @(posedge clk);
        exp_req = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_enable = 1'b1;
        #1;
        chk(tag, $sformatf("read %h", a), bus_rdata, exp_read(a));
        chk("R11", "ready in access", {31'b0, bus_ready}, 32'h1);
        @(negedge clk);
        bus_sel = 1'b0; bus_enable = 1'b0;
    endtask

    task automatic read_map(input string tag);
        rd(12'h000, tag); rd(12'h100, tag); rd(12'h104, tag); rd(12'h10C, tag);
        rd(12'h110, tag); rd(12'h118, tag); rd(12'h120, tag); rd(12'h11C, tag);
    endtask

    task automatic warm_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_warm();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic power_reset();
        @(negedge clk);
        por_n = 1'b0;
        model_warm();
        m_ret = 32'h0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    // Per-clock comparison of the pulse output and idle read data
    always @(negedge clk) begin
        #2;
        if (!done) begin
            chk("R9", "sys_reset_req", {31'b0, sys_reset_req}, {31'b0, exp_req});
            chk("R11", "ready", {31'b0, bus_ready}, 32'h1);
            if (!(bus_sel && bus_enable && !bus_write))
                chk("R11", "idle rdata", bus_rdata, 32'h0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_warm();
        m_ret = 32'h0;
        #1 por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R1 reset values
        read_map("R1");

        // R4 read/write registers hold full words
        wr(12'h100, 32'hDEAD_0001, 4'hF);
        wr(12'h104, 32'h1234_5678, 4'hF);
        wr(12'h10C, 32'hCAFE_F00D, 4'hF);
        wr(12'h110, 32'h2000_0400, 4'hF);
        wr(12'h118, 32'h0000_0003, 4'hF);
        wr(12'h120, 32'hA5A5_5A5A, 4'hF);
        read_map("R4");

        // R3 set and clear aliases
        wr(12'h004, 32'h0000_00F0, 4'hF);
        rd(12'h000, "R3");
        wr(12'h004, 32'h8000_000F, 4'hF);
        rd(12'h000, "R3");
        wr(12'h008, 32'h0000_0033, 4'hF);
        rd(12'h000, "R3");
        wr(12'h008, 32'h0000_0000, 4'hF);
        rd(12'h000, "R3");

        // R5 write-only offsets read zero
        rd(12'h004, "R5"); rd(12'h008, "R5"); rd(12'h108, "R5");

        // R6 read-only words ignore writes
        wr(12'h000, 32'hFFFF_FFFF, 4'hF);
        rd(12'h000, "R6");
        wr(12'h11C, 32'h0000_FFFF, 4'hF);
        rd(12'h11C, "R6");
        wr(12'hFE0, 32'h1111_1111, 4'hF);

        // R7 ID table
        for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(k * 4), "R7");

        // R8 byte strobes zero-pad missing lanes
        wr(12'h104, 32'hAABB_CCDD, 4'b0010);
        rd(12'h104, "R8");
        wr(12'h118, 32'h1122_3344, 4'b1100);
        rd(12'h118, "R8");
        wr(12'h004, 32'hFFFF_FFFF, 4'b0001);
        rd(12'h000, "R8");

        // R9 reset request pulse
        wr(12'h108, 32'hFFFF_FDFF, 4'hF);
        wr(12'h108, 32'h0000_0200, 4'hF);
        wr(12'h108, 32'h0000_0200, 4'b0001);
        wr(12'h108, 32'h0000_0200, 4'b0010);

        // R10 unmapped offsets
        wr(12'h114, 32'hFFFF_FFFF, 4'hF);
        wr(12'h200, 32'hFFFF_FFFF, 4'hF);
        wr(12'hFCC, 32'hFFFF_FFFF, 4'hF);
        wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
        rd(12'h114, "R10"); rd(12'h200, "R10"); rd(12'hFCC, "R10"); rd(12'h800, "R10");
        read_map("R10");

        // R2 warm reset spares retention, power-on clears it
        wr(12'h10C, 32'h0BAD_BEEF, 4'hF);
        warm_reset();
        rd(12'h10C, "R2");
        read_map("R1");
        power_reset();
        rd(12'h10C, "R2");
        read_map("R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule